// File: doc/BRIEF.md
# GPIO Hotkey Edge Detector

This block watches a bank of general-purpose input pins (24 by default) and records transitions on them so that a host can be woken up or interrupted by a key press. Every pin has its own direction bit, its own rising-edge and falling-edge enables, a two-bit function select and an interrupt-enable bit. Pull-up and pull-down choices are held as plain register bits for the pad ring. Pins are sampled through a two-stage synchroniser. An enabled transition on a pin that is an input in primary mode sets that pin's bit in two sticky registers, a detect register and a status register. Each of the two is cleared by writing 1 to it.

The whole block runs on the slow always-on clock (32 kHz class), so detection keeps working while the fast clock is stopped. The wake/interrupt request is raised only for pins whose interrupt enable is set. An edge on a pin whose enable is clear is still recorded, and it raises the request as soon as software enables that pin. The register port is a simple one-cycle write strobe with an address, plus a combinational read multiplexer.

Top module: `gpio_hotkey_bank`

## Requirements
- R1: After reset every pin is an input (direction register reads 0). The edge enables, interrupt enables, detect, status and function-select registers read 0, and `wake_req` is low.
- R2: With a pin's rising enable set, a 0-to-1 change on that pin sets the pin's bit in detect and in status. The bits are visible by the third rising clock edge after the change.
- R3: With a pin's falling enable set, a 1-to-0 change on that pin sets its detect and status bits within the same three clock edges.
- R4: With both enables set on a pin, both kinds of transition are recorded.
- R5: A transition whose direction is not enabled on that pin leaves detect and status unchanged.
- R6: A pin whose direction bit is 1 (output) records no edges.
- R7: A pin records edges only when its function select is 00, meaning bit i of both the low-select register and the high-select register is 0.
- R8: Writing 1 to a bit of detect (address 8) or of status (address 9) clears that bit. Writing 0 leaves the bit unchanged. Clearing one register does not touch the other.
- R9: If an edge is detected in the same cycle as a clear of that pin's detect bit, the bit stays set.
- R10: An edge on a pin whose interrupt enable is 0 still sets detect and status but leaves `wake_req` low. Setting that enable later raises `wake_req` on the next clock.
- R11: `wake_req` is high exactly when some pin has both its status bit and its interrupt-enable bit set. It falls once those status bits are cleared.
- R12: A pulse that lasts two clock periods is detected.
- R13: The register map is: 0 direction, 1 rising enable, 2 falling enable, 3 interrupt enable, 4 pull-up, 5 pull-down, 6 function select low bits, 7 function select high bits, 8 detect, 9 status, 10 synchronised pin level. Addresses 0 to 7 read back the value last written. Address 10 returns the pin levels two clocks after they settle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Raw pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_addr | input | 4 | Register read address |
| rd_data | output | NPINS | Read data for `rd_addr` |
| wake_req | output | 1 | Wake/interrupt request |

## Verification
A stale previous-sample flop or a missing synchroniser stage shows up at the detect register as a missed edge, a spurious edge or a change in latency. The bench therefore samples exactly three clock edges after each pin change. A qualification fault, such as a wrong direction or function-select gate, appears as a set detect bit on a pin that should stay silent. It becomes visible in the same three-cycle window. A fault in the clear-versus-set ordering or in the request gating shows on `rd_data` or `wake_req` one clock after the write or edge that exposes it.

// File: rtl/gpio_hk_pkg.sv
package gpio_hk_pkg;

  typedef enum logic [3:0] {
    SEL_DIR   = 4'd0,
    SEL_RISE  = 4'd1,
    SEL_FALL  = 4'd2,
    SEL_IEN   = 4'd3,
    SEL_PUP   = 4'd4,
    SEL_PDN   = 4'd5,
    SEL_AFLO  = 4'd6,
    SEL_AFHI  = 4'd7,
    SEL_DET   = 4'd8,
    SEL_STAT  = 4'd9,
    SEL_LEVEL = 4'd10
  } hk_sel_e;

  // One pin: does the transition prev->now count as an enabled edge?
  function automatic logic edge_hit(input logic now, input logic prev,
                                    input logic rise_en, input logic fall_en,
                                    input logic eligible);
    logic up, down;
    up   = now & ~prev;
    down = ~now & prev;
    return eligible & ((rise_en & up) | (fall_en & down));
  endfunction

  // Sticky bit update: set has priority over a write-1 clear.
  function automatic logic sticky_next(input logic cur, input logic clr,
                                       input logic set);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/gpio_hk_sync.sv
module gpio_hk_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_hk_edge.sv
module gpio_hk_edge
  import gpio_hk_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] eligible,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit[i] = edge_hit(level[i], prev_q[i], rise_en[i], fall_en[i],
                             eligible[i]);
  end
endmodule

// File: rtl/gpio_hk_cfg.sv
module gpio_hk_cfg
  import gpio_hk_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  hk_sel_e      wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] ien_q,
  output logic [W-1:0] pup_q,
  output logic [W-1:0] pdn_q,
  output logic [W-1:0] af_lo_q,
  output logic [W-1:0] af_hi_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      ien_q   <= '0;
      pup_q   <= '0;
      pdn_q   <= '0;
      af_lo_q <= '0;
      af_hi_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_DIR:  dir_q   <= wr_data;
        SEL_RISE: rise_q  <= wr_data;
        SEL_FALL: fall_q  <= wr_data;
        SEL_IEN:  ien_q   <= wr_data;
        SEL_PUP:  pup_q   <= wr_data;
        SEL_PDN:  pdn_q   <= wr_data;
        SEL_AFLO: af_lo_q <= wr_data;
        SEL_AFHI: af_hi_q <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_hk_latch.sv
module gpio_hk_latch
  import gpio_hk_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr_det,
  input  logic [W-1:0] clr_stat,
  output logic [W-1:0] det_q,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] det_d, stat_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign det_d[i]  = sticky_next(det_q[i],  clr_det[i],  hit[i]);
    assign stat_d[i] = sticky_next(stat_q[i], clr_stat[i], hit[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q  <= '0;
      stat_q <= '0;
    end else begin
      det_q  <= det_d;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/gpio_hotkey_bank.sv
module gpio_hotkey_bank
  import gpio_hk_pkg::*;
#(
  parameter int NPINS       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [NPINS-1:0] wr_data,
  input  logic [3:0]       rd_addr,
  output logic [NPINS-1:0] rd_data,
  output logic             wake_req
);
  hk_sel_e wr_sel, rd_sel;
  assign wr_sel = hk_sel_e'(wr_addr);
  assign rd_sel = hk_sel_e'(rd_addr);

  logic [NPINS-1:0] dir_q, rise_q, fall_q, ien_q, pup_q, pdn_q;
  logic [NPINS-1:0] af_lo_q, af_hi_q;
  logic [NPINS-1:0] level_s, eligible, hit_vec;
  logic [NPINS-1:0] clr_det, clr_stat, det_q, stat_q, pending;

  gpio_hk_cfg #(.W(NPINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .dir_q(dir_q), .rise_q(rise_q), .fall_q(fall_q),
    .ien_q(ien_q), .pup_q(pup_q), .pdn_q(pdn_q), .af_lo_q(af_lo_q),
    .af_hi_q(af_hi_q)
  );

  gpio_hk_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(level_s)
  );

  // Only inputs in primary function take part in detection.
  assign eligible = ~dir_q & ~af_lo_q & ~af_hi_q;

  gpio_hk_edge #(.W(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(level_s), .rise_en(rise_q),
    .fall_en(fall_q), .eligible(eligible), .hit(hit_vec)
  );

  assign clr_det  = (wr_en && wr_sel == SEL_DET)  ? wr_data : '0;
  assign clr_stat = (wr_en && wr_sel == SEL_STAT) ? wr_data : '0;

  gpio_hk_latch #(.W(NPINS)) u_latch (
    .clk(clk), .rst_n(rst_n), .hit(hit_vec), .clr_det(clr_det),
    .clr_stat(clr_stat), .det_q(det_q), .stat_q(stat_q)
  );

  assign pending  = stat_q & ien_q;
  assign wake_req = |pending;

  always_comb begin
    case (rd_sel)
      SEL_DIR:   rd_data = dir_q;
      SEL_RISE:  rd_data = rise_q;
      SEL_FALL:  rd_data = fall_q;
      SEL_IEN:   rd_data = ien_q;
      SEL_PUP:   rd_data = pup_q;
      SEL_PDN:   rd_data = pdn_q;
      SEL_AFLO:  rd_data = af_lo_q;
      SEL_AFHI:  rd_data = af_hi_q;
      SEL_DET:   rd_data = det_q;
      SEL_STAT:  rd_data = stat_q;
      SEL_LEVEL: rd_data = level_s;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_hk_checker.sv
module gpio_hk_checker #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] dir,
  input logic [W-1:0] af_lo,
  input logic [W-1:0] af_hi,
  input logic [W-1:0] ien,
  input logic [W-1:0] hit,
  input logic [W-1:0] det,
  input logic [W-1:0] stat,
  input logic         wake_req
);
  AST_INPUTS_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir == '0)); // R1

  AST_NO_HIT_INELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & (dir | af_lo | af_hi)) == '0); // R6 R7

  AST_DET_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((det & $past(hit)) == $past(hit))); // R9

  AST_STAT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((stat & $past(hit)) == $past(hit))); // R10

  AST_DET_ONLY_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (det & ~$past(det) & ~$past(hit)) == '0); // R8

  AST_REQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ((stat & ien) != '0)); // R11
endmodule

bind gpio_hotkey_bank gpio_hk_checker #(.W(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir(dir_q), .af_lo(af_lo_q), .af_hi(af_hi_q),
  .ien(ien_q), .hit(hit_vec), .det(det_q), .stat(stat_q), .wake_req(wake_req)
);

// File: tb/gpio_hotkey_bank_tb.sv
module gpio_hotkey_bank_tb;
  localparam int N = 24;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [3:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic         wake_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_hotkey_bank u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .wake_req(wake_req)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic chk(input string tag, input logic [N-1:0] got,
                     input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a,
                         input logic [N-1:0] exp);
    logic [N-1:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic clear_all();
    wr(4'd8, ALL);
    wr(4'd9, ALL);
  endtask

  initial begin
    logic [N-1:0] v;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    for (int a = 0; a < 10; a++) chk_reg("R1 reset reg", 4'(a), '0);
    chk("R1 wake_req low", {{(N-1){1'b0}}, wake_req}, '0);

    // R13 readback of configuration registers
    for (int a = 0; a < 8; a++) begin
      v = 24'h5A3C96 ^ (24'h111111 * (a + 1));
      wr(4'(a), v);
      chk_reg("R13 readback", 4'(a), v);
    end
    for (int a = 0; a < 8; a++) wr(4'(a), '0);
    clear_all();

    // R13 level register, R5 no enables -> no record
    pin_in = 24'h3C0F81;
    step(3);
    chk_reg("R13 level", 4'd10, 24'h3C0F81);
    chk_reg("R5 no enable det", 4'd8, '0);
    pin_in = '0;
    step(3);
    chk_reg("R13 level low", 4'd10, '0);

    // R2 rising sweep over every pin, with R5/R8/R11
    wr(4'd1, ALL);
    wr(4'd3, ALL);
    for (int p = 0; p < N; p++) begin
      pin_in = N'(1) << p;
      step(3);
      chk_reg("R2 rise det", 4'd8, N'(1) << p);
      chk_reg("R2 rise stat", 4'd9, N'(1) << p);
      chk("R11 req high", {{(N-1){1'b0}}, wake_req}, N'(1));
      pin_in = '0;
      step(3);
      chk_reg("R5 fall not enabled", 4'd8, N'(1) << p);
      wr(4'd8, '0);
      chk_reg("R8 write zero keeps", 4'd8, N'(1) << p);
      wr(4'd8, ALL);
      chk_reg("R8 det cleared", 4'd8, '0);
      chk_reg("R8 stat untouched", 4'd9, N'(1) << p);
      wr(4'd9, N'(1) << p);
      chk("R11 req falls", {{(N-1){1'b0}}, wake_req}, '0);
    end

    // R3 falling sweep
    wr(4'd1, '0);
    wr(4'd2, ALL);
    pin_in = ALL;
    step(3);
    clear_all();
    for (int p = 0; p < N; p++) begin
      pin_in = ALL & ~(N'(1) << p);
      step(3);
      chk_reg("R3 fall det", 4'd8, N'(1) << p);
      chk_reg("R3 fall stat", 4'd9, N'(1) << p);
      pin_in = ALL;
      step(3);
      chk_reg("R5 rise not enabled", 4'd8, N'(1) << p);
      clear_all();
    end
    pin_in = '0;
    step(3);
    clear_all();

    // R4 both edges on pin 5
    wr(4'd1, ALL);
    pin_in = N'(1) << 5;
    step(3);
    chk_reg("R4 both rise", 4'd8, N'(1) << 5);
    clear_all();
    pin_in = '0;
    step(3);
    chk_reg("R4 both fall", 4'd8, N'(1) << 5);
    clear_all();

    // R6 output pin ignored
    wr(4'd0, N'(1) << 7);
    pin_in = N'(3) << 7;
    step(3);
    chk_reg("R6 output ignored", 4'd8, N'(1) << 8);
    pin_in = '0;
    step(3);
    clear_all();
    wr(4'd0, '0);

    // R7 function select
    wr(4'd6, N'(1) << 3);
    wr(4'd7, N'(1) << 4);
    pin_in = N'(7) << 2;
    step(3);
    chk_reg("R7 only primary pin", 4'd8, N'(1) << 2);
    pin_in = '0;
    step(3);
    clear_all();
    wr(4'd6, '0);
    wr(4'd7, '0);

    // R10 disabled interrupt still records
    wr(4'd3, '0);
    pin_in = N'(1) << 9;
    step(3);
    chk_reg("R10 det set", 4'd8, N'(1) << 9);
    chk_reg("R10 stat set", 4'd9, N'(1) << 9);
    chk("R10 no req", {{(N-1){1'b0}}, wake_req}, '0);
    wr(4'd3, N'(1) << 9);
    chk("R10 req after enable", {{(N-1){1'b0}}, wake_req}, N'(1));
    pin_in = '0;
    step(3);
    clear_all();

    // R9 edge in same cycle as clear
    pin_in = N'(1) << 10;
    step(2);
    wr(4'd8, N'(1) << 10);
    chk_reg("R9 set beats clear", 4'd8, N'(1) << 10);
    pin_in = '0;
    step(3);
    clear_all();

    // R12 two-cycle pulse
    wr(4'd2, '0);
    pin_in = N'(1) << 11;
    step(2);
    pin_in = '0;
    step(3);
    chk_reg("R12 short pulse", 4'd8, N'(1) << 11);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule